// File: doc/BRIEF.md
# Two-Class QoS Memory Request Arbiter

This block decides, cycle by cycle, which of two request classes may issue to a memory controller. One class carries latency-critical traffic, such as a camera pipeline. The other carries bulk traffic, such as a graphics engine. Each class presents its own valid/ready pair, and at most one of the two is accepted in any cycle. The arbiter also drives a single grant strobe and a class tag towards memory.

Three mechanisms combine to make the decision:
- A repeating time frame reserves its opening slots for the latency-critical class.
- Outside those slots, the latency-critical class has strict priority.
- A token bucket caps how often the bulk class is served.

The bulk class can still use every cycle that the latency-critical class leaves empty, including idle reserved slots. A wait counter lifts a long-blocked bulk request above the latency-critical class in unreserved slots, so the bulk class is not starved. Ordering inside a class, memory device timing and data movement belong to other blocks.

Top module: `qos_mem_arbiter`

## Requirements
- R1: While `rst_n` is low, no grant is given. Reset leaves the frame at slot 0, the bucket full (BUCKET_MAX tokens), the refill phase at 0 and the wait count at 0.
- R2: The frame slot advances by one every cycle after reset and wraps from FRAME_LEN-1 to 0. Slots numbered below RESERVED_SLOTS are reserved; with the defaults 5 and 2, slots 0 and 1 of each five-cycle frame are reserved.
- R3: In a reserved slot, a pending latency-critical request is always granted, even when the bulk request has aged.
- R4: In a reserved slot with no latency-critical request, a pending bulk request is granted if the bucket holds a token.
- R5: In an unreserved slot, a pending latency-critical request beats a bulk request unless the bulk request has aged (R8).
- R6: A bulk grant needs at least one token and removes exactly one. With an empty bucket, a bulk request is not granted.
- R7: A refill phase counter runs from 0 to REFILL_PERIOD-1 and wraps. On the cycle where it equals REFILL_PERIOD-1, one token is added after any consumption in that cycle, unless the result would exceed BUCKET_MAX.
- R8: The wait count rises by one, saturating at AGE_MAX, in each cycle that a bulk request is pending and not granted. It clears when the bulk request is granted or withdrawn. At AGE_MAX, in an unreserved slot, a bulk request that holds a token is granted ahead of the latency-critical class.
- R9: At most one of `rt_ready` and `tp_ready` is high in a cycle. `grant_valid` is their OR, and `grant_class` is 0 for the latency-critical class and 1 for the bulk class. No grant is given when neither class is eligible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rt_valid | input | 1 | Latency-critical class has a request |
| rt_ready | output | 1 | Latency-critical request accepted this cycle |
| tp_valid | input | 1 | Bulk class has a request |
| tp_ready | output | 1 | Bulk request accepted this cycle |
| grant_valid | output | 1 | A request is issued to memory this cycle |
| grant_class | output | 1 | Class of the issued request (0 latency-critical, 1 bulk) |

## Verification
A twelve-cycle vector walk mixes both classes across two frames, and the order in which grants appear reveals each rule in turn:
- A latency-critical request winning in reserved slots versus unreserved slots shows the reserved-slot rule and strict priority apart.
- A lone bulk request in an idle reserved slot shows that slack cycles are used.
- Draining the bucket to empty shows that the token cap holds.

Three more patterns each isolate a single rule:
- Constant contention shows that aging overrides priority only in an unreserved slot.
- A continuous bulk stream shows the steady refill rate.
- A long idle spell followed by a burst shows that the bucket saturates at its ceiling.

// File: rtl/qos_arb_pkg.sv
package qos_arb_pkg;

    typedef enum logic {
        CLS_RT = 1'b0,
        CLS_TP = 1'b1
    } qos_cls_e;

    function automatic int cnt_width(input int limit);
        return (limit > 1) ? $clog2(limit) : 1;
    endfunction

endpackage

// File: rtl/qos_frame_timer.sv
module qos_frame_timer #(
    parameter int FRAME_LEN      = 5,
    parameter int RESERVED_SLOTS = 2,
    localparam int SLOT_W        = qos_arb_pkg::cnt_width(FRAME_LEN)
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [SLOT_W-1:0] slot,
    output logic              reserved
);

    typedef struct packed {
        logic [SLOT_W-1:0] slot;
    } frame_state_t;

    frame_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (state_q.slot == SLOT_W'(FRAME_LEN - 1)) begin
            state_d.slot = '0;
        end else begin
            state_d.slot = state_q.slot + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign slot     = state_q.slot;
    assign reserved = (int'(state_q.slot) < RESERVED_SLOTS);

    // R2: frame wraps after its last slot
    assert_slot_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (slot == SLOT_W'(FRAME_LEN - 1)) |=> (slot == '0));

    // R2: slot number stays inside the frame
    assert_slot_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        int'(slot) < FRAME_LEN);

endmodule

// File: rtl/qos_token_bucket.sv
module qos_token_bucket #(
    parameter int BUCKET_MAX    = 4,
    parameter int REFILL_PERIOD = 4,
    localparam int TOK_W        = qos_arb_pkg::cnt_width(BUCKET_MAX + 1),
    localparam int REF_W        = qos_arb_pkg::cnt_width(REFILL_PERIOD)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             consume,
    output logic [TOK_W-1:0] tokens,
    output logic             has_token
);

    typedef struct packed {
        logic [TOK_W-1:0] tok;
        logic [REF_W-1:0] phase;
    } bucket_state_t;

    bucket_state_t state_d, state_q;
    logic             refill;
    logic [TOK_W-1:0] after_use;

    always_comb begin
        state_d   = state_q;
        refill    = (state_q.phase == REF_W'(REFILL_PERIOD - 1));
        after_use = state_q.tok - (consume ? TOK_W'(1) : TOK_W'(0));

        state_d.phase = refill ? '0 : state_q.phase + 1'b1;

        if (refill && (after_use < TOK_W'(BUCKET_MAX))) begin
            state_d.tok = after_use + 1'b1;
        end else begin
            state_d.tok = after_use;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q.tok   <= TOK_W'(BUCKET_MAX);
            state_q.phase <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign tokens    = state_q.tok;
    assign has_token = (state_q.tok != '0);

    // R7: bucket never holds more than its ceiling
    assert_tok_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tokens <= TOK_W'(BUCKET_MAX));

    // R6: the arbiter never spends a token it does not have
    assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        consume |-> has_token);

    // R6: a spend without refill lowers the count by exactly one
    assert_spend_one_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (consume && !refill) |=> (tokens == $past(tokens) - 1'b1));

endmodule

// File: rtl/qos_wait_ager.sv
module qos_wait_ager #(
    parameter int AGE_MAX = 6,
    localparam int AGE_W  = qos_arb_pkg::cnt_width(AGE_MAX + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_pending,
    input  logic req_granted,
    output logic aged
);

    typedef struct packed {
        logic [AGE_W-1:0] wait_cnt;
    } ager_state_t;

    ager_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (!req_pending || req_granted) begin
            state_d.wait_cnt = '0;
        end else if (state_q.wait_cnt != AGE_W'(AGE_MAX)) begin
            state_d.wait_cnt = state_q.wait_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign aged = (state_q.wait_cnt == AGE_W'(AGE_MAX));

    // R8: wait count saturates at its limit
    assert_age_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        state_q.wait_cnt <= AGE_W'(AGE_MAX));

    // R8: a served request starts its wait afresh
    assert_age_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        req_granted |=> (state_q.wait_cnt == '0));

endmodule

// File: rtl/qos_mem_arbiter.sv
module qos_mem_arbiter #(
    parameter int FRAME_LEN      = 5,
    parameter int RESERVED_SLOTS = 2,
    parameter int BUCKET_MAX     = 4,
    parameter int REFILL_PERIOD  = 4,
    parameter int AGE_MAX        = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rt_valid,
    output logic rt_ready,
    input  logic tp_valid,
    output logic tp_ready,
    output logic grant_valid,
    output logic grant_class
);

    import qos_arb_pkg::*;

    localparam int SLOT_W = cnt_width(FRAME_LEN);
    localparam int TOK_W  = cnt_width(BUCKET_MAX + 1);

    logic [SLOT_W-1:0] slot;
    logic              reserved;
    logic [TOK_W-1:0]  tokens;
    logic              has_token;
    logic              aged;
    logic              tp_ok;
    qos_cls_e          win_cls;

    qos_frame_timer #(
        .FRAME_LEN      (FRAME_LEN),
        .RESERVED_SLOTS (RESERVED_SLOTS)
    ) u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .slot     (slot),
        .reserved (reserved)
    );

    qos_token_bucket #(
        .BUCKET_MAX    (BUCKET_MAX),
        .REFILL_PERIOD (REFILL_PERIOD)
    ) u_bucket (
        .clk       (clk),
        .rst_n     (rst_n),
        .consume   (tp_ready),
        .tokens    (tokens),
        .has_token (has_token)
    );

    qos_wait_ager #(
        .AGE_MAX (AGE_MAX)
    ) u_ager (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_pending (tp_valid),
        .req_granted (tp_ready),
        .aged        (aged)
    );

    always_comb begin
        rt_ready = 1'b0;
        tp_ready = 1'b0;
        tp_ok    = tp_valid && has_token;
        if (rst_n) begin
            if (reserved) begin
                if (rt_valid) begin
                    rt_ready = 1'b1;
                end else if (tp_ok) begin
                    tp_ready = 1'b1;
                end
            end else if (aged && tp_ok) begin
                tp_ready = 1'b1;
            end else if (rt_valid) begin
                rt_ready = 1'b1;
            end else if (tp_ok) begin
                tp_ready = 1'b1;
            end
        end
        win_cls = tp_ready ? CLS_TP : CLS_RT;
    end

    assign grant_valid = rt_ready | tp_ready;
    assign grant_class = logic'(win_cls);

    // R9: only one class is accepted per cycle
    assert_one_grant_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({rt_ready, tp_ready}) <= 1);

    // R9: nothing issues when nobody asks
    assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!rt_valid && !tp_valid) |-> !grant_valid);

    // R3: reserved slot belongs to a pending latency-critical request
    assert_reserved_rt_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reserved && rt_valid) |-> rt_ready);

    // R4: an idle reserved slot goes to the bulk class when a token exists
    assert_slack_use_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (reserved && !rt_valid && tp_valid && has_token) |-> tp_ready);

    // R5: strict priority in open slots until aging applies
    assert_prio_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!reserved && !aged && rt_valid) |-> (rt_ready && !tp_ready));

    // R6: bulk grants are gated by the bucket
    assert_token_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tp_ready |-> (tokens != '0));

    // R8: an aged bulk request takes an open slot
    assert_age_force_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (aged && !reserved && tp_valid && has_token) |-> tp_ready);

endmodule

// File: tb/test_qos_mem_arbiter.sv
module test_qos_mem_arbiter;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 12;

    // {rt_valid, tp_valid, expected grant_valid, expected grant_class}
    localparam logic [3:0] VEC [NVEC] = '{
        4'b1110, // k0  slot0 reserved, rt wins
        4'b0111, // k1  slot1 reserved idle, tp takes slack
        4'b1110, // k2  slot2 rt priority
        4'b0111, // k3  tp alone
        4'b0111, // k4  tp alone
        4'b0111, // k5  slot0 reserved idle, tp
        4'b0111, // k6  slot1, last token spent
        4'b0100, // k7  bucket empty, no grant
        4'b0000, // k8  idle
        4'b1010, // k9  rt alone
        4'b0000, // k10 idle
        4'b1110  // k11 slot1 reserved, rt
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rt_valid = 1'b0;
    logic tp_valid = 1'b0;
    logic rt_ready, tp_ready, grant_valid, grant_class;
    int   n_run = 0;
    int   n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    qos_mem_arbiter i_qos_mem_arbiter (
        .clk         (clk),
        .rst_n       (rst_n),
        .rt_valid    (rt_valid),
        .rt_ready    (rt_ready),
        .tp_valid    (tp_valid),
        .tp_ready    (tp_ready),
        .grant_valid (grant_valid),
        .grant_class (grant_class)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // grant encoded as {grant_valid, grant_class} plus ready consistency
    function automatic int gcode();
        return {grant_valid, grant_class, rt_ready, tp_ready};
    endfunction

    function automatic int expcode(input logic gv, input logic cls);
        return {gv, cls & gv, gv & ~cls, gv & cls};
    endfunction

    task automatic apply_reset();
        @(negedge clk);
        rst_n = 1'b0;
        rt_valid = 1'b1;
        tp_valid = 1'b1;
        #1;
        chk("R1 no grant in reset", gcode(), 0);
        repeat (2) @(negedge clk);
        rt_valid = 1'b0;
        tp_valid = 1'b0;
        rst_n = 1'b1;
    endtask

    // drive one cycle, sample before the edge, move to next window
    task automatic step(input logic rt, input logic tp, output int code);
        rt_valid = rt;
        tp_valid = tp;
        #1;
        code = gcode();
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int code;
        int cnt;

        // vector walk over two frames: R2 R3 R4 R5 R6 R7 R9
        apply_reset();
        for (int i = 0; i < NVEC; i++) begin
            step(VEC[i][3], VEC[i][2], code);
            chk($sformatf("R2/R3/R4/R5/R6/R9 vector %0d", i), code,
                expcode(VEC[i][1], VEC[i][0]));
        end

        // aging under constant contention: R8, R3, R5
        apply_reset();
        for (int k = 0; k < 8; k++) begin
            step(1'b1, 1'b1, code);
            if (k == 4) chk("R5 rt beats young tp", code, expcode(1'b1, 1'b0));
            if (k == 6) chk("R3 reserved beats aged tp", code, expcode(1'b1, 1'b0));
            if (k == 7) chk("R8 aged tp forced", code, expcode(1'b1, 1'b1));
        end

        // continuous bulk stream rate: R6 R7
        apply_reset();
        cnt = 0;
        for (int k = 0; k < 20; k++) begin
            step(1'b0, 1'b1, code);
            if (code != 0) cnt++;
        end
        chk("R7 grants in 20 cycles of bulk stream", cnt, 8);

        // idle spell then burst: R1 full bucket, R7 saturation
        apply_reset();
        cnt = 0;
        for (int k = 0; k < 16; k++) begin
            step(1'b0, 1'b0, code);
            if (code != 0) cnt++;
        end
        chk("R9 no grant while idle", cnt, 0);
        cnt = 0;
        for (int k = 0; k < 6; k++) begin
            step(1'b0, 1'b1, code);
            if (code != 0) cnt++;
            if (k == 5) chk("R6 empty bucket blocks bulk", code, 0);
        end
        chk("R7 burst after saturation", cnt, 5);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule